// File: doc/BRIEF.md
# UART Receive Holding Buffer with Overrun Detection

This block sits between a UART deserializer and the register bus. Each finished character arrives as an 8-bit word on a valid-only input stream, and software reads it back through a small word-addressed read port. A plain control pin selects between two storage modes. In holding mode there is a single register, and a new character replaces an unread one. In queue mode a first-in first-out store of `DEPTH` entries (16 by default) keeps characters in arrival order.

Two status outputs report the state of the block. Data-ready shows that at least one character is waiting. The overrun flag is sticky and shows that a character was lost or overwritten. Both can also be read from a line-status word on the bus. The receive word is reachable at its main address and at a window of sixteen further word addresses. Any of those addresses returns the head character and consumes it, so a bus master can drain the store with an incrementing burst.

The character input has no ready signal and never applies back-pressure. The deserializer cannot stall, so the block takes every presented character in the cycle it is valid and applies the overrun policy of the current mode. Read data is combinational from the current state during a cycle with `rd_en` high. Consumption and status clearing take effect at the following clock edge.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset `data_ready` and `overrun_err` are 0, and a read of any address returns 0.
- R2: In holding mode (`fifo_en`=0) a character with `char_valid`=1 is stored and `data_ready` rises the next cycle. A read of the receive word returns it in bits 7:0 and clears `data_ready` at the next edge.
- R3: In holding mode a character that arrives while `data_ready`=1 and no receive-word read is in the same cycle replaces the stored one and sets `overrun_err`. A read in the same cycle returns the old character, and the new character is stored with no overrun.
- R4: In queue mode (`fifo_en`=1) characters are returned in arrival order. Each receive-word read returns the head and removes it, and `data_ready` falls after the last entry is read.
- R5: In queue mode, a character that arrives while `DEPTH` entries are stored and no read is in the same cycle is discarded, the stored entries are unchanged, and `overrun_err` is set. With a read in the same cycle the character is accepted.
- R6: `overrun_err` stays set until a line-status read. If a new overrun happens in the same cycle as that read, the flag stays set.
- R7: `rd_data` bits 31:8 always read 0. A receive-word read while `data_ready`=0 returns 0 and has no effect.
- R8: Word addresses 12 through 27 behave exactly like the main receive word at word address 0: they return the head and consume it.
- R9: A read of word address 5 returns `data_ready` in bit 0 and `overrun_err` in bit 1 and does not consume data.
- R10: A cycle in which `fifo_en` differs from its value in the previous cycle empties the storage. A character presented in that cycle is dropped, `data_ready` is 0 in the next cycle, and `overrun_err` is unchanged.
- R11: A read of any other word address returns 0 and changes no state. With `rd_en`=0, `rd_data` is 0.
- R12: The input stream has no back-pressure. Every cycle with `char_valid`=1 is a transfer, so back-to-back characters on consecutive cycles are all taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | Completed character present (one transfer per cycle, no ready) |
| char_data | input | 8 | Received character |
| fifo_en | input | 1 | 1 = queue mode, 0 = holding mode; a change flushes storage |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 6 | Bus word address |
| rd_data | output | 32 | Bus read data, valid in the cycle of `rd_en` |
| data_ready | output | 1 | At least one character stored |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
On every cycle the assertions check the following:
- The upper read bits stay zero.
- Data-ready does not rise without an incoming character.
- The overrun flag holds until a status read.
- A mode change leaves the store empty.
- An arrival into a full store or an occupied holding register raises the overrun flag, and a full store keeps its occupancy.

Only the bench scenarios show that characters come out in arrival order. The same applies to the value returned by an overwrite, the consumption through alias addresses, and the accept-on-simultaneous-read case at the full boundary.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  // Word address of the main receive word
  localparam int unsigned RX_WORD_ADDR   = 0;
  // Word address of the line-status word
  localparam int unsigned STAT_WORD_ADDR = 5;
  // First word of the alias window for burst reads
  localparam int unsigned ALIAS_BASE     = 12;
  // Bit positions inside the line-status word
  localparam int unsigned STAT_READY_BIT = 0;
  localparam int unsigned STAT_OVR_BIT   = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RX   = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/rxb_addr_dec.sv
module rxb_addr_dec
  import uart_rxb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned ALIASES = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_sel_e           sel
);
  logic [ALIASES-1:0] alias_hit;

  // One comparator per alias word of the burst window
  for (genvar i = 0; i < ALIASES; i++) begin : g_alias
    assign alias_hit[i] = (addr == ADDR_W'(ALIAS_BASE + i));
  end

  always_comb begin
    if (addr == ADDR_W'(RX_WORD_ADDR) || (|alias_hit))
      sel = SEL_RX;
    else if (addr == ADDR_W'(STAT_WORD_ADDR))
      sel = SEL_STAT;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_mode,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              ovr_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              pop_ok, full, q_push_ok, h_push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign head      = mem[rd_ptr];
  assign pop_ok    = pop && !empty && !flush;
  assign q_push_ok = queue_mode && push && !flush && (!full || pop_ok);
  assign h_push    = !queue_mode && push && !flush;

  // Overrun events of both modes
  always_comb begin
    ovr_evt = 1'b0;
    if (!flush && push) begin
      if (queue_mode) ovr_evt = full && !pop_ok;
      else            ovr_evt = !empty && !pop_ok;
    end
  end

  // Storage write: queue mode appends at wr_ptr, holding mode overwrites the head slot
  always_ff @(posedge clk) begin
    if (q_push_ok)   mem[wr_ptr] <= push_data;
    else if (h_push) mem[rd_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (queue_mode) begin
      if (q_push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)    rd_ptr <= ptr_inc(rd_ptr);
      case ({q_push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end else begin
      if (h_push)      count <= CNT_W'(1);
      else if (pop_ok) count <= '0;
    end
  end
endmodule

// File: rtl/rxb_ovr_flag.sv
module rxb_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_rd,
  output logic flag
);
  // Set takes priority over the clearing status read
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_rd)  flag <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rxb_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ALIASES = 16,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned BUS_W   = 32,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              fifo_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              data_ready,
  output logic              overrun_err
);
  rd_sel_e           sel;
  logic              fen_q, flush;
  logic              rx_rd, stat_rd;
  logic [DATA_W-1:0] head;
  logic              empty, ovr_evt;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk) begin
    if (!rst_n) fen_q <= 1'b0;
    else        fen_q <= fifo_en;
  end

  assign flush   = (fifo_en != fen_q);
  assign rx_rd   = rd_en && (sel == SEL_RX);
  assign stat_rd = rd_en && (sel == SEL_STAT);

  rxb_addr_dec #(.ADDR_W(ADDR_W), .ALIASES(ALIASES)) dec_i (
    .addr (rd_addr),
    .sel  (sel)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_mode (fifo_en),
    .flush      (flush),
    .push       (char_valid),
    .push_data  (char_data),
    .pop        (rx_rd),
    .head       (head),
    .empty      (empty),
    .count      (count),
    .ovr_evt    (ovr_evt)
  );

  rxb_ovr_flag ovr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ovr_evt),
    .clr_rd  (stat_rd),
    .flag    (overrun_err)
  );

  assign data_ready = !empty;

  always_comb begin
    rd_data = '0;
    if (rx_rd && !empty) begin
      rd_data[DATA_W-1:0] = head;
    end else if (stat_rd) begin
      rd_data[STAT_READY_BIT] = data_ready;
      rd_data[STAT_OVR_BIT]   = overrun_err;
    end
  end
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             char_valid,
  input logic             fifo_en,
  input logic             flush,
  input logic             rx_rd,
  input logic             stat_rd,
  input logic [CNT_W-1:0] count,
  input logic [BUS_W-1:0] rd_data,
  input logic             data_ready,
  input logic             overrun_err
);
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:DATA_W] == '0);

  // R12
  no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready && !char_valid |=> !data_ready);

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err && !stat_rd |=> overrun_err);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_ready);

  // R3
  hold_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !flush && data_ready && char_valid && !rx_rd |=> overrun_err && data_ready);

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && !flush && count == CNT_W'(DEPTH) && char_valid && !rx_rd
      |=> overrun_err && count == CNT_W'(DEPTH));

  // R4
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

bind uart_rx_hold rxb_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .BUS_W(BUS_W), .CNT_W(CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .char_valid  (char_valid),
  .fifo_en     (fifo_en),
  .flush       (flush),
  .rx_rd       (rx_rd),
  .stat_rd     (stat_rd),
  .count       (count),
  .rd_data     (rd_data),
  .data_ready  (data_ready),
  .overrun_err (overrun_err)
);

// File: tb/uart_rx_hold_tb.sv
module uart_rx_hold_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = '0;
  logic        fifo_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        data_ready, overrun_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  byte unsigned q[$];
  bit m_ovr = 0;
  bit m_fen = 0;

  always #5 clk = ~clk;

  uart_rx_hold dut_i (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .fifo_en(fifo_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .data_ready(data_ready), .overrun_err(overrun_err)
  );

  function automatic bit is_rx(input logic [5:0] a);
    return (a == 6'd0) || (a >= 6'd12 && a <= 6'd27);
  endfunction

  function automatic logic [31:0] exp_rd(input logic re, input logic [5:0] a);
    if (!re) return 32'h0;
    if (is_rx(a)) return (q.size() > 0) ? {24'h0, q[0]} : 32'h0;
    if (a == 6'd5) return {30'h0, m_ovr, (q.size() > 0)};
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, check outputs before the edge, then advance the model
  task automatic step(input logic v, input logic [7:0] d, input logic re,
                      input logic [5:0] a, input logic fen);
    bit flush, pop, evt;
    @(negedge clk);
    char_valid = v; char_data = d; rd_en = re; rd_addr = a; fifo_en = fen;
    #1;
    check(fen ? "R4" : "R2", {31'h0, data_ready}, {31'h0, q.size() > 0});
    check("R6", {31'h0, overrun_err}, {31'h0, m_ovr});
    if (!re)            check("R11", rd_data, exp_rd(re, a));
    else if (a == 6'd0) check("R7", rd_data, exp_rd(re, a));
    else if (is_rx(a))  check("R8", rd_data, exp_rd(re, a));
    else if (a == 6'd5) check("R9", rd_data, exp_rd(re, a));
    else                check("R11", rd_data, exp_rd(re, a));
    flush = (fen != m_fen);
    m_fen = fen;
    evt = 0;
    if (flush) q.delete();  // R10
    else begin
      pop = re && is_rx(a) && (q.size() > 0);
      if (fen) begin
        if (pop) void'(q.pop_front());
        if (v) begin
          if (q.size() < 16) q.push_back(d);
          else evt = 1;  // R5
        end
      end else begin
        if (v) begin
          if (q.size() == 1 && !pop) evt = 1;  // R3
          q.delete();
          q.push_back(d);
        end else if (pop) q.delete();
      end
    end
    m_ovr = evt | (m_ovr & !(re && a == 6'd5));
  endtask

  task automatic idle(input logic fen);
    step(0, 8'h00, 0, 6'd0, fen);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, reads of receive, status and unused words
    step(0, 0, 1, 6'd0, 0);
    step(0, 0, 1, 6'd5, 0);
    step(0, 0, 1, 6'd3, 0);

    // R2 / R3: holding mode store, overwrite, read
    step(1, 8'hA1, 0, 6'd0, 0);
    step(1, 8'hB2, 0, 6'd0, 0);
    step(0, 0, 1, 6'd0, 0);
    step(0, 0, 1, 6'd5, 0);
    idle(0);
    // R3: read and arrival in same cycle, no overrun
    step(1, 8'h11, 0, 6'd0, 0);
    step(1, 8'h22, 1, 6'd0, 0);
    step(0, 0, 1, 6'd5, 0);
    step(0, 0, 1, 6'd13, 0);

    // R10: switch to queue mode with a character in the flush cycle
    step(1, 8'h33, 0, 6'd0, 1);
    idle(1);
    // R12 / R5: back-to-back 18 characters, last two dropped
    for (int i = 0; i < 18; i++) step(1, 8'(8'h40 + i), 0, 6'd0, 1);
    step(0, 0, 1, 6'd5, 1);
    // R5: full plus read in same cycle accepts
    step(1, 8'hEE, 1, 6'd12, 1);
    // R8 / R4: drain through the alias window in order
    for (int i = 0; i < 17; i++) step(0, 0, 1, 6'(12 + (i % 16)), 1);
    step(0, 0, 1, 6'd5, 1);
    // R6: overrun coincident with status read keeps flag set
    for (int i = 0; i < 16; i++) step(1, 8'(i), 0, 6'd0, 1);
    step(1, 8'hFF, 1, 6'd5, 1);
    step(0, 0, 1, 6'd5, 1);
    // R10: switch back flushes, overrun untouched
    step(1, 8'h77, 0, 6'd0, 0);
    step(0, 0, 1, 6'd5, 0);

    // Constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic v, re, fen;
      logic [5:0] a;
      int unsigned r;
      r = $urandom % 8;
      case (r)
        0, 1, 2: a = 6'd0;
        3, 7:    a = 6'd5;
        4, 5:    a = 6'(12 + ($urandom % 16));
        default: a = 6'($urandom % 64);
      endcase
      v = (((i / 400) % 2) == 0) ? ($urandom % 10 < 8) : ($urandom % 10 < 4);
      re = (((i / 400) % 2) == 0) ? ($urandom % 10 < 2) : ($urandom % 10 < 6);
      fen = ($urandom % 300 == 0) ? !m_fen : m_fen;
      step(v, 8'($urandom), re, a, fen);
    end
    finish_run();
  end
endmodule